// File: doc/BRIEF.md
# Exception Preemption Priority Arbiter

This block decides whether a pending exception may be taken, and which one. It holds a pending bit and an active bit for each of a small set of exception sources. Each source has its own priority value, supplied on a configuration bus. Every cycle the block finds the best pending source that the mask threshold lets through. It weighs that source against the execution mode and against the priority of the handler now running. If the source may be taken, the block raises a registered take request that carries the winning source number.

The block does not sequence the entry itself. When a handler actually begins, the sequencer pulses a start strobe with that handler's id, which moves the id from pending to active. When a handler returns, the sequencer pulses a done strobe with that id, which clears its active bit. A late-arriving exception is handled the same way. The sequencer reports a start for the late id only, and every other pending bit stays as it was. The current execution priority is derived from the active set and is given as an output.

Top module: `exc_prio_arbiter`

## Requirements
- R1: After reset, no source is pending or active. take_o is 0, exec_valid_o is 0 and exec_prio_o is all ones.
- R2: A one-cycle pulse on set_pend_i[i] makes source i pending. A pending source that is blocked by the mask or by the running handler stays pending and can be taken once it is no longer blocked.
- R3: With mask_i equal to 0 nothing is masked. With a nonzero mask_i, only sources whose priority value is strictly below mask_i are eligible.
- R4: Among the eligible sources, the one with the numerically lowest priority value wins (lower value means more urgent). On a tie, the lower source number wins.
- R5: When handler_mode_i is 0 (thread mode), any eligible source is taken, whatever the active set holds.
- R6: When handler_mode_i is 1 (handler mode), the winner is taken only if its priority value is strictly below exec_prio_o, or if no source is active. An equal value is not taken.
- R7: A start strobe with start_id_i = k clears pending bit k and sets active bit k.
- R8: A start strobe changes no pending bit other than that of start_id_i, so a source overtaken by a late arrival stays pending.
- R9: A done strobe with done_id_i = k clears active bit k. The execution priority then falls back to the remaining active sources.
- R10: exec_prio_o is the lowest priority value among the active sources, and exec_valid_o is 1. With no source active, exec_valid_o is 0 and exec_prio_o is all ones. These outputs follow the active set in the same cycle.
- R11: take_o and take_id_o are registered. They reflect the status bits and the inputs of the previous cycle, so a pulse on set_pend_i shows on take_o two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| set_pend_i | input | N_SRC | Per-source set-pending pulses |
| prio_cfg_i | input | N_SRC*PRIO_W | Priority value of source i in bits [i*PRIO_W +: PRIO_W] |
| mask_i | input | PRIO_W | Mask threshold; 0 disables masking |
| handler_mode_i | input | 1 | 0 = thread mode, 1 = handler mode |
| start_i | input | 1 | Handler start strobe |
| start_id_i | input | ID_W | Source whose handler started |
| done_i | input | 1 | Handler completion strobe |
| done_id_i | input | ID_W | Source whose handler returned |
| take_o | output | 1 | Registered take request |
| take_id_o | output | ID_W | Registered winning source number |
| exec_prio_o | output | PRIO_W | Current execution priority |
| exec_valid_o | output | 1 | At least one source is active |

## Verification
The bench builds the block with its defaults: eight sources and 3-bit priorities. The priorities are chosen so that two sources share a value, one source sits at value 0 and one at value 7. This setup reaches several cases:
- ties between equal priorities;
- a mask of 1, under which only value 0 passes;
- equal-priority refusal in handler mode;
- the "no active handler" fallback, where the lowest-urgency source is still taken.

With two levels of nesting, the bench can also show the execution priority unwinding one done strobe at a time. It can show a late arrival leaving the overtaken source pending until the running handler returns.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
  typedef enum logic {
    MODE_THREAD  = 1'b0,
    MODE_HANDLER = 1'b1
  } exc_mode_e;
endpackage

// File: rtl/exc_min_pick.sv
// Finds the lowest priority value among requesting sources; ties -> lowest index.
module exc_min_pick #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]        req_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    found_o,
  output logic [ID_W-1:0]         id_o,
  output logic [PRIO_W-1:0]       prio_o
);
  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    prio_o  = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] < prio_o)) begin
        found_o = 1'b1;
        id_o    = ID_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/exc_status_bank.sv
module exc_status_bank #(
  parameter int N_SRC = 8,
  localparam int ID_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_pend_i,
  input  logic             start_i,
  input  logic [ID_W-1:0]  start_id_i,
  input  logic             done_i,
  input  logic [ID_W-1:0]  done_id_i,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] act_o
);
  logic [N_SRC-1:0] pend_q, act_q, start_oh, done_oh;

  // start on the same id wins over done
  always_comb begin
    start_oh = '0;
    done_oh  = '0;
    if (start_i) start_oh[start_id_i] = 1'b1;
    if (done_i)  done_oh[done_id_i]   = 1'b1;
    done_oh = done_oh & ~start_oh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~start_oh) | set_pend_i;
      act_q  <= (act_q & ~done_oh) | start_oh;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;

  assert_start_activates_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> act_q[$past(start_id_i)]);

  assert_start_keeps_others_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && set_pend_i == '0) |=> ($countones(pend_q ^ $past(pend_q)) <= 1));

  assert_done_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !(start_i && start_id_i == done_id_i)) |=> !act_q[$past(done_id_i)]);
endmodule

// File: rtl/exc_prio_arbiter.sv
module exc_prio_arbiter
  import exc_arb_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(N_SRC)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        set_pend_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_cfg_i,
  input  logic [PRIO_W-1:0]       mask_i,
  input  logic                    handler_mode_i,
  input  logic                    start_i,
  input  logic [ID_W-1:0]         start_id_i,
  input  logic                    done_i,
  input  logic [ID_W-1:0]         done_id_i,
  output logic                    take_o,
  output logic [ID_W-1:0]         take_id_o,
  output logic [PRIO_W-1:0]       exec_prio_o,
  output logic                    exec_valid_o
);
  logic [N_SRC-1:0]  pend_vec, act_vec, elig_vec;
  logic              sel_found, act_found, beats, take_d;
  logic [ID_W-1:0]   sel_id, act_id;
  logic [PRIO_W-1:0] sel_prio, act_prio;
  exc_mode_e         mode;

  exc_status_bank #(.N_SRC(N_SRC)) u_bank (
    .clk_i, .rst_ni, .set_pend_i,
    .start_i, .start_id_i, .done_i, .done_id_i,
    .pend_o(pend_vec), .act_o(act_vec)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    assign elig_vec[g] = pend_vec[g] &&
      (mask_i == '0 || prio_cfg_i[g*PRIO_W +: PRIO_W] < mask_i);
  end

  exc_min_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_pick_pend (
    .req_i(elig_vec), .prio_i(prio_cfg_i),
    .found_o(sel_found), .id_o(sel_id), .prio_o(sel_prio)
  );

  exc_min_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_pick_act (
    .req_i(act_vec), .prio_i(prio_cfg_i),
    .found_o(act_found), .id_o(act_id), .prio_o(act_prio)
  );

  assign mode         = exc_mode_e'(handler_mode_i);
  assign exec_valid_o = act_found;
  assign exec_prio_o  = act_found ? act_prio : '1;

  // handler mode needs strict preemption; no active handler counts as lowest
  always_comb begin
    beats = 1'b1;
    if (mode == MODE_HANDLER && act_found) beats = (sel_prio < act_prio);
    take_d = sel_found && beats;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o    <= 1'b0;
      take_id_o <= '0;
    end else begin
      take_o    <= take_d;
      take_id_o <= sel_id;
    end
  end

  logic unused_act_id;
  assign unused_act_id = ^act_id;

  assert_take_was_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> |(($past(pend_vec) >> take_id_o) & {{(N_SRC-1){1'b0}}, 1'b1}));

  assert_take_under_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && $past(mask_i) != '0) |-> ($past(sel_prio) < $past(mask_i)));

  assert_handler_strict_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && $past(handler_mode_i) && $past(exec_valid_o)) |->
      ($past(sel_prio) < $past(exec_prio_o)));

  assert_exec_none_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_vec == '0) |-> (!exec_valid_o && exec_prio_o == '1));
endmodule

// File: tb/sim_exc_prio_arbiter.sv
module sim_exc_prio_arbiter;
  localparam int N = 8;
  localparam int PW = 3;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] set_pend = '0;
  logic [N*PW-1:0] prio_cfg;
  logic [PW-1:0] mask = '0;
  logic hmode = 1'b0;
  logic start = 1'b0, done = 1'b0;
  logic [IW-1:0] start_id = '0, done_id = '0;
  logic take;
  logic [IW-1:0] take_id;
  logic [PW-1:0] exec_prio;
  logic exec_valid;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  exc_prio_arbiter #(.N_SRC(N), .PRIO_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .set_pend_i(set_pend), .prio_cfg_i(prio_cfg),
    .mask_i(mask), .handler_mode_i(hmode), .start_i(start), .start_id_i(start_id),
    .done_i(done), .done_id_i(done_id), .take_o(take), .take_id_o(take_id),
    .exec_prio_o(exec_prio), .exec_valid_o(exec_valid)
  );

  // priorities: src0=5 src1=3 src2=3 src3=1 src4=6 src5=0 src6=7 src7=2
  function automatic logic [PW-1:0] prio_of(int i);
    case (i)
      0: return 3'd5; 1: return 3'd3; 2: return 3'd3; 3: return 3'd1;
      4: return 3'd6; 5: return 3'd0; 6: return 3'd7; default: return 3'd2;
    endcase
  endfunction

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_take(logic et, logic [IW-1:0] eid, string req);
    n_run++;
    if (take !== et || (et && take_id !== eid)) begin
      n_fail++;
      $display("FAIL %s: take=%0b id=%0d expected take=%0b id=%0d", req, take, take_id, et, eid);
    end
  endtask

  task automatic chk_exec(logic ev, logic [PW-1:0] ep, string req);
    n_run++;
    if (exec_valid !== ev || exec_prio !== ep) begin
      n_fail++;
      $display("FAIL %s: exec valid=%0b prio=%0d expected valid=%0b prio=%0d",
               req, exec_valid, exec_prio, ev, ep);
    end
  endtask

  task automatic pend(logic [N-1:0] v);
    set_pend = v; tick(); set_pend = '0; tick();
  endtask

  task automatic do_start(int id);
    start = 1'b1; start_id = IW'(id); tick(); start = 1'b0; tick();
  endtask

  task automatic do_done(int id);
    done = 1'b1; done_id = IW'(id); tick(); done = 1'b0; tick();
  endtask

  task automatic service(int id);
    do_start(id); do_done(id);
  endtask

  task automatic t_reset;
    chk_take(1'b0, '0, "R1");
    chk_exec(1'b0, 3'd7, "R1");
  endtask

  task automatic t_basic_nesting;
    hmode = 1'b0;
    set_pend = 8'h10; tick();
    set_pend = '0;
    chk_take(1'b0, '0, "R11 one edge after pulse");
    tick();
    chk_take(1'b1, 3'd4, "R11 two edges after pulse");
    do_start(4);
    chk_exec(1'b1, 3'd6, "R7 start activates");
    chk_take(1'b0, '0, "R7 pending cleared");
    hmode = 1'b1;
    pend(8'h40);
    chk_take(1'b0, '0, "R6 lower urgency in handler");
    pend(8'h01);
    chk_take(1'b1, 3'd0, "R6 nested preemption");
    do_start(0);
    chk_exec(1'b1, 3'd5, "R10 nested exec prio");
    chk_take(1'b0, '0, "R6 blocked by nested");
    do_done(0);
    chk_exec(1'b1, 3'd6, "R9 unwind one level");
    do_done(4);
    chk_exec(1'b0, 3'd7, "R9 unwind to none");
    chk_take(1'b1, 3'd6, "R6 no active handler");
    service(6);
    chk_take(1'b0, '0, "R9 all serviced");
    hmode = 1'b0;
  endtask

  task automatic t_tie;
    pend(8'h06);
    chk_take(1'b1, 3'd1, "R4 tie to lower id");
    pend(8'h08);
    chk_take(1'b1, 3'd3, "R4 lowest value wins");
    do_start(3);
    chk_take(1'b1, 3'd1, "R5 thread ignores active");
    do_start(1);
    chk_take(1'b1, 3'd2, "R5 thread ignores active");
    do_start(2);
    chk_take(1'b0, '0, "R7 all started");
    chk_exec(1'b1, 3'd1, "R10 min of active set");
    do_done(3);
    chk_exec(1'b1, 3'd3, "R9 exec falls back");
    do_done(1); do_done(2);
    chk_exec(1'b0, 3'd7, "R10 none active");
  endtask

  task automatic t_mask;
    mask = 3'd3;
    pend(8'h13);
    chk_take(1'b0, '0, "R3 values >= mask blocked");
    pend(8'h80);
    chk_take(1'b1, 3'd7, "R3 value below mask");
    service(7);
    chk_take(1'b0, '0, "R3 rest masked");
    mask = 3'd0; tick();
    chk_take(1'b1, 3'd1, "R2 masked source stayed pending");
    service(1);
    chk_take(1'b1, 3'd0, "R2 next pending");
    service(0);
    chk_take(1'b1, 3'd4, "R2 next pending");
    service(4);
    mask = 3'd1;
    pend(8'h08);
    chk_take(1'b0, '0, "R3 mask 1 blocks value 1");
    pend(8'h20);
    chk_take(1'b1, 3'd5, "R3 mask 1 passes value 0");
    service(5);
    mask = 3'd0; tick();
    chk_take(1'b1, 3'd3, "R3 mask 0 disables masking");
    service(3);
    chk_take(1'b0, '0, "R3 drained");
  endtask

  task automatic t_late;
    hmode = 1'b0;
    pend(8'h10);
    chk_take(1'b1, 3'd4, "R4 single source");
    pend(8'h20);
    chk_take(1'b1, 3'd5, "R4 late arrival outranks");
    do_start(5);
    chk_exec(1'b1, 3'd0, "R7 late id active");
    chk_take(1'b1, 3'd4, "R5 thread takes despite active");
    hmode = 1'b1; tick();
    chk_take(1'b0, '0, "R6 handler blocks");
    do_done(5);
    chk_take(1'b1, 3'd4, "R8 overtaken source still pending");
    hmode = 1'b0;
    service(4);
    chk_take(1'b0, '0, "R8 drained");
  endtask

  task automatic t_equal;
    hmode = 1'b0;
    pend(8'h02);
    chk_take(1'b1, 3'd1, "R5 thread entry");
    do_start(1);
    hmode = 1'b1;
    pend(8'h04);
    chk_take(1'b0, '0, "R6 equal priority not taken");
    pend(8'h80);
    chk_take(1'b1, 3'd7, "R6 strictly higher taken");
    service(7);
    chk_take(1'b0, '0, "R6 equal still blocked");
    do_done(1);
    chk_take(1'b1, 3'd2, "R2 equal source kept pending");
    service(2);
    chk_exec(1'b0, 3'd7, "R9 all returned");
    hmode = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) prio_cfg[i*PW +: PW] = prio_of(i);
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_basic_nesting();
    t_tie();
    t_mask();
    t_late();
    t_equal();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule